// File: doc/BRIEF.md
# Register-window DMA burst sequencer

This block puts a small bank of 16-bit peripheral registers behind a simple word-addressed register bus. It also gives a DMA engine a single fixed data-window address through which it can reach a contiguous run of those registers. A configuration register holds two 5-bit fields: a base index and a burst length. Each access to the window address is steered to the bank register at index base plus a running offset. The offset then advances by one, and it wraps back to zero after the programmed number of transfers.

A DMA channel is pointed at the window address. It performs bursts of length+1 transfers and so refreshes several registers without reprogramming its own address. Software can also read and write every bank register directly at its own index.

Read data is combinational: it is valid in the cycle the access is presented. Writes take effect at the rising clock edge on which `bus_en` and `bus_we` are high.

Top module: `reg_window_dma`

## Requirements
- R1: After reset, the configuration register reads 0x0000 and the burst offset is zero, so the first window access reaches bank index 0.
- R2: The configuration register sits at bus index 32. Base index is in bits 4:0 and burst length is in bits 12:8. Bits 15:13 and bits 7:5 always read as zero, whatever was written.
- R3: An access (read or write) to the window address, bus index 33, reaches the bank register at index base+offset. The offset then increments by one.
- R4: For a burst-length value N (any 5-bit value), a burst spans N+1 transfers. After the transfer at offset N, the offset returns to zero, so the next window access reaches the base again. Examples: N=0 is 1 transfer, N=2 is 3 transfers, N=17 is 18 transfers.
- R5: Writing the configuration register resets the offset to zero.
- R6: A window access whose target index base+offset is 24 or more reads as zero and changes no register. The offset still advances as in R3 and R4.
- R7: Bank registers 0 to 23 are read and written directly at bus indices 0 to 23. Direct reads and writes do not alter other registers.
- R8: Accesses to any address other than the window address, and idle cycles, leave the offset unchanged. Reading the configuration register is included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word index: 0-23 bank, 32 configuration, 33 window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for the addressed word |

## Verification
The hardest state to reach is a window access that lands outside the bank in the middle of a burst that also wraps. Reaching it needs a large base, a long length and a counter position that can only be reached by a series of earlier accesses. Directed bursts of 1, 3 and 18 transfers place the offset at each wrap point. A burst with base 20 then walks the target past index 23 while ignored writes are checked through direct reads. A random phase then mixes configuration rewrites, direct accesses and window accesses, so that offset resets land at arbitrary counter positions.

// File: rtl/reg_window_dma.sv
module reg_window_dma #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int FIELD_W    = 5,
  parameter int LEN_LSB    = 8,
  parameter int BANK_DEPTH = 24,
  parameter int CFG_ADDR   = 32,
  parameter int WIN_ADDR   = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SUM_W = FIELD_W + 1;
  localparam int SEL_W = (ADDR_W > SUM_W) ? ADDR_W : SUM_W;
  localparam int HI_PAD = DATA_W - LEN_LSB - FIELD_W;
  localparam int LO_PAD = LEN_LSB - FIELD_W;

  logic [FIELD_W-1:0] base_q, len_q, offset_q;
  logic [DATA_W-1:0]  bank_q [BANK_DEPTH];
  logic [DATA_W-1:0]  bank_rd;

  wire hit_cfg = bus_addr == ADDR_W'(CFG_ADDR);
  wire hit_win = bus_addr == ADDR_W'(WIN_ADDR);
  wire cfg_wr  = bus_en && bus_we && hit_cfg;
  wire win_acc = bus_en && hit_win;

  wire [SUM_W-1:0] target = SUM_W'(base_q) + SUM_W'(offset_q);
  wire [SEL_W-1:0] sel    = hit_win ? SEL_W'(target) : SEL_W'(bus_addr);

  wire [DATA_W-1:0] cfg_word = {{HI_PAD{1'b0}}, len_q, {LO_PAD{1'b0}}, base_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      len_q    <= '0;
      offset_q <= '0;
    end else if (cfg_wr) begin
      base_q   <= bus_wdata[FIELD_W-1:0];
      len_q    <= bus_wdata[LEN_LSB +: FIELD_W];
      offset_q <= '0;
    end else if (win_acc) begin
      offset_q <= (offset_q == len_q) ? '0 : offset_q + 1'b1;
    end
  end

  for (genvar i = 0; i < BANK_DEPTH; i++) begin : g_bank
    wire wr_hit = bus_en && bus_we && (sel == SEL_W'(i)) && !hit_cfg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bank_q[i] <= '0;
      else if (wr_hit) bank_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    bank_rd = '0;
    for (int i = 0; i < BANK_DEPTH; i++)
      if (sel == SEL_W'(i)) bank_rd = bank_q[i];
  end

  assign bus_rdata = hit_cfg ? cfg_word : bank_rd;
endmodule

module reg_window_dma_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 6,
  parameter int FIELD_W  = 5,
  parameter int CFG_ADDR = 32,
  parameter int WIN_ADDR = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [FIELD_W-1:0] offset_q,
  input logic [FIELD_W-1:0] len_q
);
  wire c_win = bus_en && bus_addr == ADDR_W'(WIN_ADDR);
  wire c_cfw = bus_en && bus_we && bus_addr == ADDR_W'(CFG_ADDR);
  wire c_cfr = bus_en && bus_addr == ADDR_W'(CFG_ADDR);

  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    offset_q <= len_q); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    c_win && offset_q == len_q |=> offset_q == '0); // R4
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    c_win && offset_q != len_q |=> offset_q == $past(offset_q) + 1'b1); // R3
  AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    c_cfw |=> offset_q == '0); // R5
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c_win && !c_cfw |=> $stable(offset_q)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    c_cfr |-> bus_rdata[15:13] == 3'b0 && bus_rdata[7:5] == 3'b0); // R2
endmodule

bind reg_window_dma reg_window_dma_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
  .CFG_ADDR(CFG_ADDR), .WIN_ADDR(WIN_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .offset_q(offset_q), .len_q(len_q)
);

// File: tb/test_reg_window_dma.sv
module test_reg_window_dma;
  localparam int DEPTH = 24;
  localparam logic [5:0] CFG = 6'd32;
  localparam logic [5:0] WIN = 6'd33;

  logic clk = 0, rst_n = 0, bus_en = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_bank [DEPTH];
  int m_base = 0, m_len = 0, m_off = 0;

  always #2.5 clk = ~clk;

  reg_window_dma i_reg_window_dma (.clk(clk), .rst_n(rst_n), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [15:0] cfg_word();
    return 16'((m_len << 8) | m_base);
  endfunction

  function automatic int tgt();
    return m_base + m_off;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(bit we, logic [5:0] a, logic [15:0] d, output logic [15:0] rd);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1 bus_en = 0; bus_we = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    logic [15:0] rd;
    access(1, a, d, rd);
    if (a == CFG) begin
      m_base = int'(d[4:0]); m_len = int'(d[12:8]); m_off = 0;
    end else if (a == WIN) begin
      if (tgt() < DEPTH) m_bank[tgt()] = d;
      m_off = (m_off == m_len) ? 0 : m_off + 1;
    end else if (a < DEPTH) m_bank[a] = d;
  endtask

  task automatic rd_chk(string req, logic [5:0] a);
    logic [15:0] rd, exp;
    if (a == CFG) exp = cfg_word();
    else if (a == WIN) exp = (tgt() < DEPTH) ? m_bank[tgt()] : 16'h0;
    else if (a < DEPTH) exp = m_bank[a];
    else exp = 16'h0;
    access(0, a, 16'h0, rd);
    if (a == WIN) m_off = (m_off == m_len) ? 0 : m_off + 1;
    check(req, rd, exp);
  endtask

  task automatic check_bank(string req);
    for (int i = 0; i < DEPTH; i++) rd_chk(req, 6'(i));
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < DEPTH; i++) m_bank[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd_chk("R1 cfg reset", CFG);
    wr(WIN, 16'hA5A5);
    rd_chk("R1 first window to index 0", 6'd0);

    for (int i = 0; i < DEPTH; i++) wr(6'(i), 16'h1000 + 16'(i));
    check_bank("R7 direct access");

    wr(CFG, 16'hFFFF);
    rd_chk("R2 reserved bits zero", CFG);
    wr(CFG, 16'h0A13);
    rd_chk("R2 field positions", CFG);

    wr(CFG, 16'h0002);
    for (int k = 0; k < 4; k++) wr(WIN, 16'h2200 + 16'(k));
    rd_chk("R4 single-transfer burst", 6'd2);
    rd_chk("R4 single-transfer neighbour", 6'd3);

    wr(CFG, 16'h0205);
    for (int k = 0; k < 3; k++) wr(WIN, 16'h3300 + 16'(k));
    wr(WIN, 16'h3399);
    check_bank("R3 three-transfer burst and wrap R4");

    wr(CFG, 16'h1104);
    for (int k = 0; k < 18; k++) wr(WIN, 16'h4400 + 16'(k));
    wr(WIN, 16'h44EE);
    check_bank("R4 eighteen-transfer burst");
    for (int k = 0; k < 20; k++) rd_chk("R3 window read sequence", WIN);

    wr(CFG, 16'h0714);
    for (int k = 0; k < 8; k++) wr(WIN, 16'h5500 + 16'(k));
    check_bank("R6 out-of-range writes ignored");
    for (int k = 0; k < 8; k++) rd_chk("R6 out-of-range reads zero", WIN);

    wr(CFG, 16'h0500);
    wr(WIN, 16'h6600); wr(WIN, 16'h6601); rd_chk("R8 cfg read keeps offset", CFG);
    rd_chk("R8 direct read keeps offset", 6'd9); wr(6'd10, 16'h6610);
    wr(WIN, 16'h6602);
    rd_chk("R8 offset held", 6'd2);
    wr(CFG, 16'h0500);
    wr(WIN, 16'h6677);
    rd_chk("R5 cfg write restarts burst", 6'd0);

    for (int k = 0; k < 600; k++) begin
      int op = int'($urandom_range(0, 9));
      case (op)
        0: wr(CFG, 16'($urandom));
        1: rd_chk("R2 random cfg read", CFG);
        2, 3: wr(WIN, 16'($urandom));
        4, 5: rd_chk("R3 random window read", WIN);
        6: wr(6'($urandom_range(0, DEPTH - 1)), 16'($urandom));
        7: rd_chk("R7 random direct read", 6'($urandom_range(0, DEPTH - 1)));
        8: rd_chk("R6 unmapped address read", 6'($urandom_range(DEPTH, 31)));
        default: wr(6'($urandom_range(34, 63)), 16'($urandom));
      endcase
    end
    check_bank("R7 final bank");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule